// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a synchronous DRAM from the device side. On every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable levels into one decoded command code. It keeps the open or closed state of each of the four banks and the row address held open in each. Every command that the current state forbids raises a one-cycle illegal flag, and such a command changes no state.

Clock enable works with a one-cycle delay. The level seen at one edge decides whether the next edge acts at all. A refresh encoding at an edge where clock enable drops is taken as self-refresh entry. Two timing guards are kept: a lockout window after a mode-register write, and a busy window while a burst with auto precharge runs. When that burst ends, its bank closes on its own.

All pins are plain control and status signals with no handshake. The decoded code, the flag and the latched column change one clock after the edge that sampled the command. Bank state and open rows change at that same edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With cs_n high at an enabled edge, the code is NOP (0) and no bank state changes, whatever ras_n, cas_n and we_n carry.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 000 gives MRS (1); 001 gives AREF (2), or SREF (3) when cke is low at that edge; 011 gives ACT (4); 101 gives RD (5), or RDA (6) with addr[10] high; 100 gives WR (7), or WRA (8) with addr[10] high; 110 gives BST (9); 010 gives PRE (10), or PREA (11) with addr[10] high; 111 gives NOP (0).
- R3: Bank-select value {ba[1],ba[0]} maps 00 to bank 0, 10 to bank 1, 01 to bank 2 and 11 to bank 3. bank_active bit i is bank i.
- R4: A legal ACT marks its bank active and stores the 12-bit addr as that bank's row in open_rows bits [12*i+11:12*i]. The row is kept after the bank closes.
- R5: A legal RD, RDA, WR or WRA latches addr[8:0] on rw_col.
- R6: PRE closes the selected bank. PREA closes every bank and ignores ba. Neither is ever illegal.
- R7: MRS, AREF and SREF are illegal while any bank is active.
- R8: For 2 enabled edges after a legal MRS, any command other than NOP is illegal.
- R9: After a legal RDA or WRA, every RD, RDA, WR or WRA is illegal for the next 4 edges. The burst's bank closes at the 4th edge, and a read or write to another open bank is legal from the 5th.
- R10: RD, RDA, WR, WRA or BST to an idle bank, and ACT to an active bank, raise illegal for one cycle and leave bank_active and open_rows unchanged.
- R11: An edge following one that sampled cke low is frozen: the code is FRZ (12), illegal stays low and nothing changes. The first command is accepted at the edge after cke returns high.
- R12: Reset leaves every bank idle, every stored row zero, the code NOP, illegal low and rw_col zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; acts from the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select {ba[1],ba[0]} |
| addr | input | 12 | Row, column or A10 qualifier |
| cmd_code | output | 4 | Decoded command of the previous edge |
| illegal | output | 1 | Previous command was illegal |
| bank_active | output | 4 | Open flag per bank |
| open_rows | output | 48 | Stored row per bank, bank 0 in the low bits |
| rw_col | output | 9 | Column of the last legal read or write |

## Verification
Every result of a command sampled at a rising edge is due one cycle later. cmd_code, illegal and rw_col come from registers loaded at that edge, and bank_active and open_rows change at the same edge. The driver applies each command at a falling edge and queues the expected code, flag and bank state. The monitor pops that entry 2 ns after the next rising edge, so each comparison falls in exactly the cycle the command acts. The busy window of an auto-precharge burst and the lockout after MRS are checked edge by edge through this same queue, including the last rejected edge and the first accepted one.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MRS  = 4'd1,
    CMD_AREF = 4'd2,
    CMD_SREF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_RDA  = 4'd6,
    CMD_WR   = 4'd7,
    CMD_WRA  = 4'd8,
    CMD_BST  = 4'd9,
    CMD_PRE  = 4'd10,
    CMD_PREA = 4'd11,
    CMD_FRZ  = 4'd12
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              run,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic              ap_bit,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank_idx
);
  // bank index is the bit-reversed select value (10 -> bank 1, 01 -> bank 2)
  always_comb begin
    for (int i = 0; i < BANK_W; i++) bank_idx[i] = ba[BANK_W-1-i];
  end

  always_comb begin
    cmd = CMD_NOP;
    if (!run) cmd = CMD_FRZ;
    else if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000: cmd = CMD_MRS;
        3'b001: cmd = cke ? CMD_AREF : CMD_SREF;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = ap_bit ? CMD_RDA : CMD_RD;
        3'b100: cmd = ap_bit ? CMD_WRA : CMD_WR;
        3'b110: cmd = CMD_BST;
        3'b010: cmd = ap_bit ? CMD_PREA : CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_trk_guard.sv
module sdram_trk_guard #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int MRS_LOCK  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 mrs_go,
  input  logic                 ap_go,
  input  logic [BANK_W-1:0]    ap_bank_in,
  input  logic [NUM_BANKS-1:0] pre_mask,
  output logic                 lock,
  output logic                 ap_busy,
  output logic [NUM_BANKS-1:0] ap_done_mask
);
  localparam int LOCK_W = $clog2(MRS_LOCK + 1);
  localparam int AP_W   = $clog2(BURST_LEN + 1);

  logic [LOCK_W-1:0] lock_cnt;
  logic [AP_W-1:0]   ap_cnt;
  logic [BANK_W-1:0] ap_bank;
  logic              ap_end;

  assign lock   = (lock_cnt != '0);
  assign ap_end = ap_busy && run && (ap_cnt == AP_W'(1));
  assign ap_done_mask = ap_end ? (NUM_BANKS'(1) << ap_bank) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_cnt <= '0;
    else if (mrs_go) lock_cnt <= LOCK_W'(MRS_LOCK);
    else if (run && lock) lock_cnt <= lock_cnt - LOCK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_busy <= 1'b0;
      ap_cnt  <= '0;
      ap_bank <= '0;
    end else if (ap_go) begin
      ap_busy <= 1'b1;
      ap_cnt  <= AP_W'(BURST_LEN);
      ap_bank <= ap_bank_in;
    end else if (ap_busy && pre_mask[ap_bank]) begin
      ap_busy <= 1'b0;
    end else if (ap_busy && run) begin
      if (ap_end) ap_busy <= 1'b0;
      else ap_cnt <= ap_cnt - AP_W'(1);
    end
  end

  assert_lock_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cnt <= LOCK_W'(MRS_LOCK));
  assert_mrs_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_go |=> lock);
  assert_ap_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ap_go |=> ap_busy);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_en,
  input  logic [BANK_W-1:0]          act_bank,
  input  logic [ROW_W-1:0]           act_row,
  input  logic [NUM_BANKS-1:0]       idle_mask,
  output logic [NUM_BANKS-1:0]       active,
  output logic [NUM_BANKS*ROW_W-1:0] rows
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[i] <= 1'b0;
        row_q     <= '0;
      end else if (idle_mask[i]) begin
        active[i] <= 1'b0;
      end else if (act_en && act_bank == BANK_W'(i)) begin
        active[i] <= 1'b1;
        row_q     <= act_row;
      end
    end
    assign rows[i*ROW_W +: ROW_W] = row_q;
  end

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> active[$past(act_bank)]);
  assert_idle_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mask != '0 && !act_en) |=> ((active & $past(idle_mask)) == '0));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  parameter int MRS_LOCK  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [3:0]                 cmd_code,
  output logic                       illegal,
  output logic [(1<<BANK_W)-1:0]     bank_active,
  output logic [(1<<BANK_W)*ROW_W-1:0] open_rows,
  output logic [COL_W-1:0]           rw_col
);
  localparam int NUM_BANKS = 1 << BANK_W;

  logic                 cke_prev;
  cmd_e                 cmd_c, cmd_q;
  logic [BANK_W-1:0]    bidx;
  logic                 ill_c, ok, sel_active, any_active, is_rw;
  logic                 lock, ap_busy, act_en, mrs_go, ap_go;
  logic [NUM_BANKS-1:0] pre_mask, ap_done_mask, idle_mask;

  sdram_cmd_decode #(.BANK_W(BANK_W)) u_dec (
    .run(cke_prev), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .ap_bit(addr[AP_BIT]), .cmd(cmd_c), .bank_idx(bidx)
  );

  assign sel_active = bank_active[bidx];
  assign any_active = |bank_active;
  assign is_rw = (cmd_c == CMD_RD) || (cmd_c == CMD_RDA) ||
                 (cmd_c == CMD_WR) || (cmd_c == CMD_WRA);

  always_comb begin
    ill_c = 1'b0;
    if (lock && cmd_c != CMD_NOP && cmd_c != CMD_FRZ) ill_c = 1'b1;
    else begin
      case (cmd_c)
        CMD_MRS, CMD_AREF, CMD_SREF: ill_c = any_active;
        CMD_ACT:                     ill_c = sel_active;
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: ill_c = !sel_active || ap_busy;
        CMD_BST:                     ill_c = !sel_active;
        default:                     ill_c = 1'b0;
      endcase
    end
  end

  assign ok     = !ill_c;
  assign act_en = ok && (cmd_c == CMD_ACT);
  assign mrs_go = ok && (cmd_c == CMD_MRS);
  assign ap_go  = ok && ((cmd_c == CMD_RDA) || (cmd_c == CMD_WRA));

  always_comb begin
    pre_mask = '0;
    if (cmd_c == CMD_PREA) pre_mask = '1;
    else if (cmd_c == CMD_PRE) pre_mask = NUM_BANKS'(1) << bidx;
  end
  assign idle_mask = pre_mask | ap_done_mask;

  sdram_trk_guard #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .BURST_LEN(BURST_LEN), .MRS_LOCK(MRS_LOCK)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .run(cke_prev), .mrs_go(mrs_go), .ap_go(ap_go),
    .ap_bank_in(bidx), .pre_mask(pre_mask), .lock(lock), .ap_busy(ap_busy),
    .ap_done_mask(ap_done_mask)
  );

  sdram_bank_tracker #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_bank(bidx),
    .act_row(addr), .idle_mask(idle_mask), .active(bank_active), .rows(open_rows)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev <= 1'b1;
      cmd_q    <= CMD_NOP;
      illegal  <= 1'b0;
      rw_col   <= '0;
    end else begin
      cke_prev <= cke;
      cmd_q    <= cmd_c;
      illegal  <= ill_c;
      if (ok && is_rw) rw_col <= addr[COL_W-1:0];
    end
  end
  assign cmd_code = cmd_q;

  assert_frozen_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_prev |=> (cmd_code == CMD_FRZ && !illegal && $stable(bank_active)));
  assert_mrs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_MRS && !illegal) |-> ($past(bank_active) == '0));
  assert_prea_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_c == CMD_PREA) |=> (bank_active == '0));
  assert_bad_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_c == CMD_ACT && ill_c && !ap_busy) |=> $stable(bank_active));
  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_prev && cs_n) |=> (cmd_code == CMD_NOP && !illegal));
endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
  localparam logic [3:0] C_NOP = 0, C_MRS = 1, C_AREF = 2, C_SREF = 3, C_ACT = 4,
    C_RD = 5, C_RDA = 6, C_WR = 7, C_BST = 9, C_PRE = 10, C_PREA = 11, C_FRZ = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmd_code;
  logic        illegal;
  logic [3:0]  bank_active;
  logic [47:0] open_rows;
  logic [8:0]  rw_col;

  int n_checks = 0, n_errors = 0;

  typedef struct {
    logic [3:0] code;
    logic       ill;
    logic [3:0] banks;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .illegal(illegal), .bank_active(bank_active), .open_rows(open_rows),
    .rw_col(rw_col)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply one command at a falling edge, queue its expected outcome
  task automatic step(input logic k, input logic [3:0] rcw_cs, input logic [1:0] b,
                      input logic [11:0] a, input logic [3:0] ec, input logic ei,
                      input logic [3:0] eb, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = rcw_cs;
    ba = b;
    addr = a;
    e.code = ec; e.ill = ei; e.banks = eb; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: results of the edge are due right after it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {cmd_code, illegal, bank_active}, {e.code, e.ill, e.banks});
      end
    end
  end

  task automatic after_edge();
    @(posedge clk);
    #3;
  endtask

  localparam logic [3:0] P_NOP = 4'b0111, P_MRS = 4'b0000, P_REF = 4'b0001,
    P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100, P_BST = 4'b0110,
    P_PRE = 4'b0010, P_DES = 4'b1011;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R12 reset code/ill/banks", {cmd_code, illegal, bank_active}, {C_NOP, 1'b0, 4'h0});
    check("R12 reset rows", open_rows, 48'h0);
    check("R12 reset col", rw_col, 9'h0);
    @(negedge clk);
    rst_n = 1'b1;

    step(1, P_NOP, 2'b00, 12'h000, C_NOP, 0, 4'b0000, "R2 nop");
    step(1, P_DES, 2'b00, 12'h000, C_NOP, 0, 4'b0000, "R1 deselected act");
    step(1, P_ACT, 2'b00, 12'hABC, C_ACT, 0, 4'b0001, "R4 act bank0");
    step(1, P_ACT, 2'b10, 12'h123, C_ACT, 0, 4'b0011, "R3 sel 10 -> bank1");
    step(1, P_ACT, 2'b01, 12'h456, C_ACT, 0, 4'b0111, "R3 sel 01 -> bank2");
    after_edge();
    check("R4 rows stored", open_rows[35:0], 36'h456_123_ABC);
    step(1, P_ACT, 2'b10, 12'hFFF, C_ACT, 1, 4'b0111, "R10 act active bank");
    step(1, P_MRS, 2'b00, 12'h000, C_MRS, 1, 4'b0111, "R7 mrs with open bank");
    after_edge();
    check("R10 row unchanged", open_rows[23:12], 12'h123);
    step(1, P_RD, 2'b00, 12'h1A5, C_RD, 0, 4'b0111, "R5 read bank0");
    after_edge();
    check("R5 col latched", rw_col, 9'h1A5);
    step(1, P_WR, 2'b10, 12'h0F0, C_WR, 0, 4'b0111, "R2 write bank1");
    step(1, P_BST, 2'b11, 12'h000, C_BST, 1, 4'b0111, "R10 bst idle bank3");
    step(1, P_RD, 2'b11, 12'h033, C_RD, 1, 4'b0111, "R10 read idle bank3");
    after_edge();
    check("R5 col kept on illegal", rw_col, 9'h0F0);
    step(1, P_PRE, 2'b01, 12'h000, C_PRE, 0, 4'b0011, "R6 pre bank2");
    step(1, P_PRE, 2'b00, 12'h400, C_PREA, 0, 4'b0000, "R6 pre all");
    after_edge();
    check("R4 rows kept after close", open_rows[35:0], 36'h456_123_ABC);
    step(1, P_REF, 2'b00, 12'h000, C_AREF, 0, 4'b0000, "R7 aref all idle");
    step(1, P_MRS, 2'b00, 12'h023, C_MRS, 0, 4'b0000, "R7 mrs all idle");
    step(1, P_ACT, 2'b00, 12'h777, C_ACT, 1, 4'b0000, "R8 lockout edge 1");
    step(1, P_ACT, 2'b00, 12'h777, C_ACT, 1, 4'b0000, "R8 lockout edge 2");
    step(1, P_ACT, 2'b00, 12'h777, C_ACT, 0, 4'b0001, "R8 lockout over");
    step(1, P_ACT, 2'b10, 12'h011, C_ACT, 0, 4'b0011, "R2 act bank1");
    step(1, P_RD, 2'b00, 12'h405, C_RDA, 0, 4'b0011, "R9 read auto-pre bank0");
    step(1, P_WR, 2'b10, 12'h001, C_WR, 1, 4'b0011, "R9 busy edge 1");
    step(1, P_NOP, 2'b00, 12'h000, C_NOP, 0, 4'b0011, "R9 busy edge 2");
    step(1, P_NOP, 2'b00, 12'h000, C_NOP, 0, 4'b0011, "R9 busy edge 3");
    step(1, P_RD, 2'b10, 12'h002, C_RD, 1, 4'b0010, "R9 busy edge 4, bank0 closes");
    step(1, P_RD, 2'b10, 12'h003, C_RD, 0, 4'b0010, "R9 other bank after burst");
    step(1, P_ACT, 2'b00, 12'h222, C_ACT, 0, 4'b0011, "R9 reopen bank0");
    step(1, P_PRE, 2'b11, 12'h400, C_PREA, 0, 4'b0000, "R6 pre all ignores ba");
    step(0, P_NOP, 2'b00, 12'h000, C_NOP, 0, 4'b0000, "R11 cke drops");
    step(0, P_ACT, 2'b00, 12'h100, C_FRZ, 0, 4'b0000, "R11 frozen act");
    step(1, P_ACT, 2'b00, 12'h100, C_FRZ, 0, 4'b0000, "R11 still frozen");
    step(1, P_ACT, 2'b00, 12'h100, C_ACT, 0, 4'b0001, "R11 act after wake");
    step(1, P_PRE, 2'b00, 12'h400, C_PREA, 0, 4'b0000, "R6 close all");
    step(0, P_REF, 2'b00, 12'h000, C_SREF, 0, 4'b0000, "R2 self refresh entry");
    step(0, P_NOP, 2'b00, 12'h000, C_FRZ, 0, 4'b0000, "R11 in self refresh");
    step(1, P_NOP, 2'b00, 12'h000, C_FRZ, 0, 4'b0000, "R11 exit edge");
    step(1, P_ACT, 2'b11, 12'h0AA, C_ACT, 0, 4'b1000, "R3 sel 11 -> bank3");
    step(1, P_REF, 2'b00, 12'h000, C_AREF, 1, 4'b1000, "R7 aref with open bank");
    step(1, P_NOP, 2'b00, 12'h000, C_NOP, 0, 4'b1000, "R2 idle tail");
    after_edge();
    check("R4 bank3 row", open_rows[47:36], 12'h0AA);
    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule